// File: doc/BRIEF.md
# Raster Block Transfer Engine

The engine copies a rectangle of 16-bit words from one area of memory to another. On the way it merges each source word with the word already at the destination under any of the sixteen two-input boolean functions. A processor programs a small bank of registers with the two start addresses, the rectangle's width and height in words, and four signed address steps. It then sets a go bit in the control register and waits until the busy flag drops. Through a single word-wide request/grant master port, the engine reads the source word, reads the destination word, and writes the merged result back to the destination. It skips either read when it does not need that word.

A sixteen-entry pattern table can stand in for the source or be mixed into it. This lets the same engine fill areas with halftone patterns. The table row follows a line counter that starts at a programmed row and moves on once per line. Three edge masks choose which destination bits a write may change: one for the first word of a line, one for the last, and one for the words in between. Bits outside the mask keep their old value. Separate per-word and end-of-line steps, each signed, let a move run in either direction, so overlapping regions can be handled.

Top module: `blit_engine`

## Requirements
- R1: Configuration registers, selected by `cfg_addr`, are written on `cfg_we` while idle and read back on `cfg_rdata` (zero-extended), and all read 0 after reset. Register 0 holds the source address, 1 the destination address, 2 the words per line, 3 the line count, 4/5 the source word/line steps, 6/7 the destination word/line steps, and 8/9/10 the first/middle/last edge masks. Register 11 is control: op in bits 3:0, pattern mode in bits 5:4, first pattern row in bits 11:8, and the go/busy flag in bit 15. Addresses 16 to 31 hold pattern rows 0 to 15.
- R2: While `busy` is high, every configuration write is ignored, a second go included.
- R3: For each bit, with s the effective source bit and d the old destination bit, the merged bit equals op[3 - (2*s + d)]. So op 0 clears, op 3 copies the source, op 5 keeps the destination, op 6 is exclusive-or, and op 15 sets.
- R4: The written word is (merged & mask) | (old_destination & ~mask).
- R5: The first word of each line uses the first mask, the last word uses the last mask, and the others use the middle mask. A line only one word wide uses the first mask.
- R6: The effective source depends on the pattern mode: 0 gives the source word, 1 the pattern row alone, 2 the source AND the row, and 3 the source XOR the row. The row index is the first pattern row plus the line number, taken modulo 16.
- R7: Per word, the engine reads the source (when needed), then reads the destination (when needed), then writes the destination. While a request waits for a grant, the request, direction, address and write data hold steady, and no request is raised when the engine is idle.
- R8: After each word that is not the last on its line, the source and destination addresses add their signed word steps. After the last word of a line, they add their signed line steps instead.
- R9: `busy` rises on the cycle after an accepted go and falls after the last write of the last line is granted. The line-count register then reads 0, and the address registers read their stepped final values.
- R10: A go with a word count or line count of zero makes no memory access and leaves `busy` low.
- R11: The source read is skipped in pattern mode 1 and whenever op does not depend on the source. The destination read is skipped when op does not depend on the destination and the word's mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Grant; the access completes on a clock edge where request and grant are both high |
| mem_rdata | input | 16 | Read data, valid in the granted cycle |

## Verification
Plain copies with full masks separate the address-step logic from the merge logic. The next set of runs uses three distinct edge masks and one-word lines, which shows whether the mask is selected by position or by order. Pattern-only runs whose first row sits near the top of the table check the row wrap and the omitted source read. A sweep over all sixteen opcodes under a stalling grant checks both the truth-table indexing and the hold behaviour. Descending, zero-size and go-while-busy runs cover the signed steps, the empty transfer and the write lockout.

// File: rtl/blit_pkg.sv
// Shared definitions for the block transfer engine.
// Assumes a 16-entry pattern table and a 5-bit configuration address space.
package blit_pkg;
    localparam int HT_DEPTH  = 16;
    localparam int HT_IDX_W  = $clog2(HT_DEPTH);
    localparam int CFG_AW    = 5;
    localparam int WORD_W    = 16;

    localparam logic [CFG_AW-1:0] REG_SRC    = 5'd0;
    localparam logic [CFG_AW-1:0] REG_DST    = 5'd1;
    localparam logic [CFG_AW-1:0] REG_XCNT   = 5'd2;
    localparam logic [CFG_AW-1:0] REG_YCNT   = 5'd3;
    localparam logic [CFG_AW-1:0] REG_SXINC  = 5'd4;
    localparam logic [CFG_AW-1:0] REG_SYINC  = 5'd5;
    localparam logic [CFG_AW-1:0] REG_DXINC  = 5'd6;
    localparam logic [CFG_AW-1:0] REG_DYINC  = 5'd7;
    localparam logic [CFG_AW-1:0] REG_MFIRST = 5'd8;
    localparam logic [CFG_AW-1:0] REG_MMID   = 5'd9;
    localparam logic [CFG_AW-1:0] REG_MLAST  = 5'd10;
    localparam logic [CFG_AW-1:0] REG_CTRL   = 5'd11;

    localparam int CTRL_GO_BIT = 15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SRC  = 2'd1,
        ST_DST  = 2'd2,
        ST_WR   = 2'd3
    } blit_state_e;

    typedef enum logic [1:0] {
        PAT_OFF  = 2'd0,
        PAT_ONLY = 2'd1,
        PAT_AND  = 2'd2,
        PAT_XOR  = 2'd3
    } pat_mode_e;

    // True when the merge result can change with the source bit.
    function automatic logic op_needs_src(input logic [3:0] op);
        return op[1:0] != op[3:2];
    endfunction

    // True when the merge result can change with the destination bit.
    function automatic logic op_needs_dst(input logic [3:0] op);
        return {op[2], op[0]} != {op[3], op[1]};
    endfunction
endpackage

// File: rtl/blit_regfile.sv
// Configuration registers, pattern table and working address/count state.
// Assumes writes are taken only while idle; the sequencer steps addresses
// through step_word/step_line while busy. ADDR_W must exceed INC_W.
module blit_regfile
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int INC_W  = 16,
    parameter int CFG_DW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    output logic [CFG_DW-1:0]   cfg_rdata,
    input  logic                engine_busy,
    input  logic                step_word,
    input  logic                step_line,
    input  logic [HT_IDX_W-1:0] ht_idx,
    output logic                go,
    output logic [ADDR_W-1:0]   src_addr,
    output logic [ADDR_W-1:0]   dst_addr,
    output logic [CNT_W-1:0]    x_count,
    output logic [CNT_W-1:0]    y_count,
    output logic [WORD_W-1:0]   mask_first,
    output logic [WORD_W-1:0]   mask_mid,
    output logic [WORD_W-1:0]   mask_last,
    output logic [3:0]          op,
    output pat_mode_e           pat_mode,
    output logic [HT_IDX_W-1:0] pat_start,
    output logic [WORD_W-1:0]   pat_word
);
    localparam int EXT_W = ADDR_W - INC_W;

    logic [INC_W-1:0]  src_xinc, src_yinc, dst_xinc, dst_yinc;
    logic [WORD_W-1:0] pat_mem [HT_DEPTH];
    logic              busy_all;
    logic              cfg_hit;
    logic              go_req;

    assign busy_all = engine_busy | go;
    assign cfg_hit  = cfg_we & ~busy_all;
    assign go_req   = cfg_hit && (cfg_addr == REG_CTRL) && cfg_wdata[CTRL_GO_BIT]
                      && (x_count != '0) && (y_count != '0);

    // Sign-extend a step to address width.
    function automatic logic [ADDR_W-1:0] sext(input logic [INC_W-1:0] v);
        return {{EXT_W{v[INC_W-1]}}, v};
    endfunction

    // Register go one cycle so the sequencer sees the newly written opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) go <= 1'b0;
        else        go <= go_req;
    end

    // Program registers from the host and step working state during a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr   <= '0;
            dst_addr   <= '0;
            x_count    <= '0;
            y_count    <= '0;
            src_xinc   <= '0;
            src_yinc   <= '0;
            dst_xinc   <= '0;
            dst_yinc   <= '0;
            mask_first <= '0;
            mask_mid   <= '0;
            mask_last  <= '0;
            op         <= '0;
            pat_mode   <= PAT_OFF;
            pat_start  <= '0;
        end else if (step_word) begin
            if (step_line) begin
                src_addr <= src_addr + sext(src_yinc);
                dst_addr <= dst_addr + sext(dst_yinc);
                y_count  <= y_count - 1'b1;
            end else begin
                src_addr <= src_addr + sext(src_xinc);
                dst_addr <= dst_addr + sext(dst_xinc);
            end
        end else if (cfg_hit && !cfg_addr[CFG_AW-1]) begin
            case (cfg_addr)
                REG_SRC:    src_addr   <= cfg_wdata[ADDR_W-1:0];
                REG_DST:    dst_addr   <= cfg_wdata[ADDR_W-1:0];
                REG_XCNT:   x_count    <= cfg_wdata[CNT_W-1:0];
                REG_YCNT:   y_count    <= cfg_wdata[CNT_W-1:0];
                REG_SXINC:  src_xinc   <= cfg_wdata[INC_W-1:0];
                REG_SYINC:  src_yinc   <= cfg_wdata[INC_W-1:0];
                REG_DXINC:  dst_xinc   <= cfg_wdata[INC_W-1:0];
                REG_DYINC:  dst_yinc   <= cfg_wdata[INC_W-1:0];
                REG_MFIRST: mask_first <= cfg_wdata[WORD_W-1:0];
                REG_MMID:   mask_mid   <= cfg_wdata[WORD_W-1:0];
                REG_MLAST:  mask_last  <= cfg_wdata[WORD_W-1:0];
                REG_CTRL: begin
                    op        <= cfg_wdata[3:0];
                    pat_mode  <= pat_mode_e'(cfg_wdata[5:4]);
                    pat_start <= cfg_wdata[8 +: HT_IDX_W];
                end
                default: ;
            endcase
        end
    end

    // Pattern table rows, written through the upper half of the address space.
    generate
        for (genvar r = 0; r < HT_DEPTH; r++) begin : g_pat
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pat_mem[r] <= '0;
                else if (cfg_hit && cfg_addr[CFG_AW-1] && (cfg_addr[HT_IDX_W-1:0] == HT_IDX_W'(r)))
                    pat_mem[r] <= cfg_wdata[WORD_W-1:0];
            end
        end
    endgenerate

    assign pat_word = pat_mem[ht_idx];

    // Readback multiplexer for the host.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr[CFG_AW-1]) begin
            cfg_rdata = CFG_DW'(pat_mem[cfg_addr[HT_IDX_W-1:0]]);
        end else begin
            case (cfg_addr)
                REG_SRC:    cfg_rdata = CFG_DW'(src_addr);
                REG_DST:    cfg_rdata = CFG_DW'(dst_addr);
                REG_XCNT:   cfg_rdata = CFG_DW'(x_count);
                REG_YCNT:   cfg_rdata = CFG_DW'(y_count);
                REG_SXINC:  cfg_rdata = CFG_DW'(src_xinc);
                REG_SYINC:  cfg_rdata = CFG_DW'(src_yinc);
                REG_DXINC:  cfg_rdata = CFG_DW'(dst_xinc);
                REG_DYINC:  cfg_rdata = CFG_DW'(dst_yinc);
                REG_MFIRST: cfg_rdata = CFG_DW'(mask_first);
                REG_MMID:   cfg_rdata = CFG_DW'(mask_mid);
                REG_MLAST:  cfg_rdata = CFG_DW'(mask_last);
                REG_CTRL: begin
                    cfg_rdata[3:0]              = op;
                    cfg_rdata[5:4]              = pat_mode;
                    cfg_rdata[8 +: HT_IDX_W]    = pat_start;
                    cfg_rdata[CTRL_GO_BIT]      = busy_all;
                end
                default: cfg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/blit_combine.sv
// Merge datapath: mixes the pattern row into the source, applies the
// four-bit truth table per bit, then protects bits outside the mask.
// Purely combinational; assumes the inputs are held while a write waits.
module blit_combine
    import blit_pkg::*;
(
    input  logic [WORD_W-1:0] src_word,
    input  logic [WORD_W-1:0] dst_word,
    input  logic [WORD_W-1:0] pat_word,
    input  pat_mode_e         pat_mode,
    input  logic [3:0]        op,
    input  logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] result
);
    logic [WORD_W-1:0] eff_src;
    logic [WORD_W-1:0] merged;

    // Choose the effective source according to the pattern mode.
    always_comb begin
        case (pat_mode)
            PAT_ONLY: eff_src = pat_word;
            PAT_AND:  eff_src = src_word & pat_word;
            PAT_XOR:  eff_src = src_word ^ pat_word;
            default:  eff_src = src_word;
        endcase
    end

    // One truth-table lookup per bit; index 0 is source=1, destination=1.
    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            assign merged[b] = op[{~eff_src[b], ~dst_word[b]}];
        end
    endgenerate

    assign result = (merged & mask) | (dst_word & ~mask);
endmodule

// File: rtl/blit_sequencer.sv
// Walks the rectangle word by word: optional source read, optional
// destination read, then the write. Picks the edge mask from the position
// in the line and advances the pattern row once per line.
// Assumes x_count and y_count are non-zero when go is raised.
module blit_sequencer
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [CNT_W-1:0]    x_count,
    input  logic [CNT_W-1:0]    y_count,
    input  logic [WORD_W-1:0]   mask_first,
    input  logic [WORD_W-1:0]   mask_mid,
    input  logic [WORD_W-1:0]   mask_last,
    input  logic [3:0]          op,
    input  pat_mode_e           pat_mode,
    input  logic [HT_IDX_W-1:0] pat_start,
    input  logic [ADDR_W-1:0]   src_addr,
    input  logic [ADDR_W-1:0]   dst_addr,
    input  logic                mem_gnt,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                busy,
    output logic                step_word,
    output logic                step_line,
    output logic [HT_IDX_W-1:0] ht_idx,
    output logic [WORD_W-1:0]   src_q,
    output logic [WORD_W-1:0]   dst_q,
    output logic [WORD_W-1:0]   cur_mask
);
    blit_state_e       state;
    logic [CNT_W-1:0]  x_left;
    logic              line_end;
    logic              last_line;
    logic              need_src;
    logic [WORD_W-1:0] next_mask;

    assign line_end  = (x_left == CNT_W'(1));
    assign last_line = (y_count == CNT_W'(1));
    assign need_src  = (pat_mode != PAT_ONLY) && op_needs_src(op);

    // Destination is fetched unless every bit is overwritten independently of it.
    function automatic logic need_dst(input logic [WORD_W-1:0] m);
        return op_needs_dst(op) || (m != '1);
    endfunction

    // First state of a word given the mask it will use.
    function automatic blit_state_e word_entry(input logic [WORD_W-1:0] m);
        if (need_src)    return ST_SRC;
        if (need_dst(m)) return ST_DST;
        return ST_WR;
    endfunction

    // Mask of the word in flight and of the word that follows it.
    always_comb begin
        if (x_left == x_count)      cur_mask = mask_first;
        else if (line_end)          cur_mask = mask_last;
        else                        cur_mask = mask_mid;
        if (line_end)               next_mask = mask_first;
        else if (x_left == CNT_W'(2)) next_mask = mask_last;
        else                        next_mask = mask_mid;
    end

    // Main walk through source read, destination read and write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            x_left <= '0;
            ht_idx <= '0;
            src_q  <= '0;
            dst_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    x_left <= x_count;
                    ht_idx <= pat_start;
                    state  <= word_entry(mask_first);
                end
                ST_SRC: if (mem_gnt) begin
                    src_q <= mem_rdata;
                    state <= need_dst(cur_mask) ? ST_DST : ST_WR;
                end
                ST_DST: if (mem_gnt) begin
                    dst_q <= mem_rdata;
                    state <= ST_WR;
                end
                ST_WR: if (mem_gnt) begin
                    if (line_end) begin
                        x_left <= x_count;
                        ht_idx <= ht_idx + 1'b1;
                        state  <= last_line ? ST_IDLE : word_entry(next_mask);
                    end else begin
                        x_left <= x_left - 1'b1;
                        state  <= word_entry(next_mask);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (state == ST_WR);
    assign mem_addr  = (state == ST_SRC) ? src_addr : dst_addr;
    assign step_word = mem_we && mem_gnt;
    assign step_line = step_word && line_end;
endmodule

// File: rtl/blit_engine.sv
// Top of the block transfer engine: register bank, sequencer and merge path.
// Assumes a single memory master port where an access completes on a clock
// edge with request and grant both high, read data valid in that cycle.
module blit_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int INC_W  = 16,
    parameter int CFG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [15:0]       mem_rdata
);
    logic                go;
    logic                seq_busy;
    logic                step_word, step_line;
    logic [HT_IDX_W-1:0] ht_idx;
    logic [ADDR_W-1:0]   src_addr, dst_addr;
    logic [CNT_W-1:0]    x_count, y_count;
    logic [WORD_W-1:0]   mask_first, mask_mid, mask_last, cur_mask;
    logic [3:0]          op;
    pat_mode_e           pat_mode;
    logic [HT_IDX_W-1:0] pat_start;
    logic [WORD_W-1:0]   pat_word, src_q, dst_q;

    assign busy = seq_busy | go;

    blit_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .INC_W(INC_W), .CFG_DW(CFG_DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .engine_busy(seq_busy), .step_word(step_word), .step_line(step_line),
        .ht_idx(ht_idx), .go(go),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .x_count(x_count), .y_count(y_count),
        .mask_first(mask_first), .mask_mid(mask_mid), .mask_last(mask_last),
        .op(op), .pat_mode(pat_mode), .pat_start(pat_start), .pat_word(pat_word)
    );

    blit_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go),
        .x_count(x_count), .y_count(y_count),
        .mask_first(mask_first), .mask_mid(mask_mid), .mask_last(mask_last),
        .op(op), .pat_mode(pat_mode), .pat_start(pat_start),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .busy(seq_busy), .step_word(step_word), .step_line(step_line),
        .ht_idx(ht_idx), .src_q(src_q), .dst_q(dst_q), .cur_mask(cur_mask)
    );

    blit_combine u_comb (
        .src_word(src_q), .dst_word(dst_q), .pat_word(pat_word),
        .pat_mode(pat_mode), .op(op), .mask(cur_mask), .result(mem_wdata)
    );
endmodule

// File: rtl/blit_engine_checker.sv
// Protocol and completion properties for the block transfer engine,
// attached to every instance of the top through bind.
module blit_engine_checker #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata,
    input logic              cfg_we,
    input logic [4:0]        cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic [CNT_W-1:0]  x_count,
    input logic [CNT_W-1:0]  y_count
);
    // R7: no memory request while idle
    assert_req_needs_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R7: a waiting request keeps all its fields
    assert_hold_while_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R9: busy ends only right after a granted write
    assert_end_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_req && mem_gnt && mem_we));

    // R9: line count is exhausted when busy ends
    assert_lines_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (y_count == '0));

    // R10: an empty rectangle never raises busy
    assert_empty_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we && cfg_addr == 5'd11 && cfg_wdata[15] && (x_count == '0 || y_count == '0)) |=> !busy);
endmodule

bind blit_engine blit_engine_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .x_count(x_count), .y_count(y_count)
);

// File: tb/blit_engine_bench.sv
// Self-checking bench: a behavioural model predicts every memory access
// as a queue; each granted access is compared on the clock it occurs.
module blit_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        busy, mem_req, mem_we, mem_gnt;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    logic [15:0] mem     [1024];
    logic [15:0] ref_mem [1024];
    logic [15:0] pat [16];

    logic [23:0] q_addr [$];
    logic        q_we   [$];
    logic [15:0] q_data [$];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit stall = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    int g_src, g_dst, g_xc, g_yc, g_sxi, g_syi, g_dxi, g_dyi;
    logic [15:0] g_m1, g_m2, g_m3;
    logic [3:0]  g_op;
    logic [1:0]  g_mode;
    logic [3:0]  g_hts;
    int fin_src, fin_dst;

    logic [23:0] ea;
    logic        ew;
    logic [15:0] ed;

    blit_engine u_blit_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:0]];

    // memory write on a granted write request
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n && mem_req && mem_gnt && mem_we) mem[mem_addr[9:0]] = mem_wdata;
    end

    // grant driven just after the edge, optionally stalling
    always @(posedge clk) begin
        #1;
        lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_gnt = !stall || (lfsr[1:0] != 2'b00);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of each granted access against the model
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_gnt) begin
            if (q_addr.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R7 unexpected access: actual=%0h expected=none", mem_addr);
            end else begin
                ea = q_addr.pop_front();
                ew = q_we.pop_front();
                ed = q_data.pop_front();
                check(mem_addr === ea && mem_we === ew, "R7/R8", "access address", {7'd0, mem_we, mem_addr}, {7'd0, ew, ea});
                if (ew) check(mem_wdata === ed, "R3/R4", "write data", {16'd0, mem_wdata}, {16'd0, ed});
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input logic [4:0] a, input logic [31:0] exp, input string req);
        cfg_addr = a;
        #1;
        check(cfg_rdata === exp, req, $sformatf("readback reg %0d", a), cfg_rdata, exp);
    endtask

    // merged bit from the truth-table rule of R3
    function automatic bit op_bit(input logic [3:0] op, input bit s, input bit d);
        int idx;
        idx = 3 - (2 * int'(s) + int'(d));
        return op[idx];
    endfunction

    // builds expected accesses and final memory image for the current setup
    task automatic build_model();
        int s, d;
        bit us, ud, use_s, use_d;
        logic [15:0] mk, sv, dv, hv, rv, wv;
        s = g_src; d = g_dst;
        us = 0; ud = 0;
        for (int b = 0; b < 2; b++) begin
            if (op_bit(g_op, 1'b0, b[0]) != op_bit(g_op, 1'b1, b[0])) us = 1;
            if (op_bit(g_op, b[0], 1'b0) != op_bit(g_op, b[0], 1'b1)) ud = 1;
        end
        for (int y = 0; y < g_yc; y++) begin
            hv = pat[(int'(g_hts) + y) % 16];
            for (int x = 0; x < g_xc; x++) begin
                if (x == 0)             mk = g_m1;
                else if (x == g_xc - 1) mk = g_m3;
                else                    mk = g_m2;
                use_s = (g_mode != 2'd1) && us;
                use_d = ud || (mk != 16'hFFFF);
                sv = ref_mem[s & 1023];
                dv = ref_mem[d & 1023];
                if (use_s) begin q_addr.push_back(24'(s)); q_we.push_back(1'b0); q_data.push_back(16'h0); end
                if (use_d) begin q_addr.push_back(24'(d)); q_we.push_back(1'b0); q_data.push_back(16'h0); end
                case (g_mode)
                    2'd1: sv = hv;
                    2'd2: sv = sv & hv;
                    2'd3: sv = sv ^ hv;
                    default: ;
                endcase
                for (int b = 0; b < 16; b++) rv[b] = op_bit(g_op, sv[b], dv[b]);
                wv = (rv & mk) | (dv & ~mk);
                ref_mem[d & 1023] = wv;
                q_addr.push_back(24'(d)); q_we.push_back(1'b1); q_data.push_back(wv);
                if (x == g_xc - 1) begin s = s + g_syi; d = d + g_dyi; end
                else               begin s = s + g_sxi; d = d + g_dxi; end
            end
        end
        fin_src = s & 24'hFFFFFF;
        fin_dst = d & 24'hFFFFFF;
    endtask

    task automatic program_regs();
        cfg_write(5'd0,  32'(g_src));
        cfg_write(5'd1,  32'(g_dst));
        cfg_write(5'd2,  32'(g_xc));
        cfg_write(5'd3,  32'(g_yc));
        cfg_write(5'd4,  {16'd0, 16'(g_sxi)});
        cfg_write(5'd5,  {16'd0, 16'(g_syi)});
        cfg_write(5'd6,  {16'd0, 16'(g_dxi)});
        cfg_write(5'd7,  {16'd0, 16'(g_dyi)});
        cfg_write(5'd8,  {16'd0, g_m1});
        cfg_write(5'd9,  {16'd0, g_m2});
        cfg_write(5'd10, {16'd0, g_m3});
    endtask

    task automatic run_blit(input string req, input bit inject);
        int w;
        int bad;
        int first;
        program_regs();
        build_model();
        cfg_write(5'd11, {16'd0, 1'b1, 3'd0, g_hts, 2'd0, g_mode, g_op});
        if (inject) begin
            cfg_write(5'd8, 32'h1234);
            cfg_write(5'd11, {16'd0, 1'b1, 15'd0});
        end
        w = 0;
        while (busy && w < 20000) begin @(negedge clk); w++; end
        check(!busy, req, "busy after run", {31'd0, busy}, 32'd0);
        check(q_addr.size() == 0, req, "accesses left over", q_addr.size(), 0);
        q_addr.delete(); q_we.delete(); q_data.delete();
        bad = 0; first = -1;
        for (int i = 0; i < 1024; i++)
            if (mem[i] !== ref_mem[i]) begin bad++; if (first < 0) first = i; end
        if (first < 0) first = 0;
        check(bad == 0, req, $sformatf("memory image word %0d", first), {16'd0, mem[first]}, {16'd0, ref_mem[first]});
        for (int i = 0; i < 1024; i++) ref_mem[i] = mem[i];
        cfg_check(5'd3, 32'd0, "R9");
        cfg_check(5'd0, 32'(fin_src), "R8");
        cfg_check(5'd1, 32'(fin_dst), "R8");
        if (inject) cfg_check(5'd8, {16'd0, g_m1}, "R2");
    endtask

    task automatic setup(input int src, input int dst, input int xc, input int yc,
                         input int sxi, input int syi, input int dxi, input int dyi);
        g_src = src; g_dst = dst; g_xc = xc; g_yc = yc;
        g_sxi = sxi; g_syi = syi; g_dxi = dxi; g_dyi = dyi;
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 5'd0; cfg_wdata = 32'd0; mem_gnt = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 16'(i * 40503) ^ 16'h5A3C;
            ref_mem[i] = mem[i];
        end
        for (int i = 0; i < 16; i++) pat[i] = 16'(i * 4369) ^ 16'h8001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R1 registers zero, R9 idle, R7 no request
        check(busy === 1'b0, "R9", "busy after reset", {31'd0, busy}, 32'd0);
        check(mem_req === 1'b0, "R7", "request after reset", {31'd0, mem_req}, 32'd0);
        cfg_check(5'd0, 32'd0, "R1");
        cfg_check(5'd9, 32'd0, "R1");

        // R1 readback of several registers
        cfg_write(5'd5, 32'h0000_FFF3);
        cfg_check(5'd5, 32'h0000_FFF3, "R1");
        cfg_write(5'd11, 32'h0000_0A27);
        cfg_check(5'd11, 32'h0000_0A27, "R1");
        for (int i = 0; i < 16; i++) cfg_write(5'(16 + i), {16'd0, pat[i]});
        cfg_check(5'd21, {16'd0, pat[5]}, "R1");

        // R3 plain copy, full masks, R8 line stride
        setup(100, 300, 4, 3, 1, 13, 1, 13);
        g_m1 = 16'hFFFF; g_m2 = 16'hFFFF; g_m3 = 16'hFFFF;
        g_op = 4'd3; g_mode = 2'd0; g_hts = 4'd0;
        run_blit("R3", 0);

        // R4/R5 distinct first, middle, last masks with xor
        setup(120, 320, 3, 2, 1, 14, 1, 14);
        g_m1 = 16'h00FF; g_m2 = 16'hF0F0; g_m3 = 16'hFF00; g_op = 4'd6;
        run_blit("R4", 0);

        // R5 one-word lines use only the first mask
        setup(140, 340, 1, 3, 5, 2, 5, 2);
        g_m1 = 16'h0F0F; g_m2 = 16'h3333; g_m3 = 16'hF000; g_op = 4'd3;
        run_blit("R5", 0);

        // R6/R11 pattern only, rows wrap from 14
        setup(160, 360, 2, 4, 1, 15, 1, 15);
        g_m1 = 16'hFFFF; g_m2 = 16'hFFFF; g_m3 = 16'hFFFF;
        g_op = 4'd3; g_mode = 2'd1; g_hts = 4'd14;
        run_blit("R6", 0);

        // R6 pattern AND, pattern XOR
        setup(180, 380, 3, 3, 1, 14, 1, 14);
        g_op = 4'd7; g_mode = 2'd2; g_hts = 4'd3;
        run_blit("R6", 0);
        g_op = 4'd6; g_mode = 2'd3; g_hts = 4'd9;
        run_blit("R6", 0);

        // R8 descending source, mixed destination steps
        setup(600, 700, 4, 3, -1, -13, 2, 9);
        g_op = 4'd3; g_mode = 2'd0; g_hts = 4'd0;
        g_m1 = 16'hFFF0; g_m2 = 16'hFFFF; g_m3 = 16'h0FFF;
        run_blit("R8", 0);

        // R11 clear with full masks: no reads; set with partial mask: no source read
        setup(200, 400, 3, 2, 1, 14, 1, 14);
        g_m1 = 16'hFFFF; g_m2 = 16'hFFFF; g_m3 = 16'hFFFF; g_op = 4'd0;
        run_blit("R11", 0);
        g_m1 = 16'h8001; g_op = 4'd15;
        run_blit("R11", 0);

        // R3 every opcode under a stalling grant (R7 hold)
        stall = 1'b1;
        for (int k = 0; k < 16; k++) begin
            setup(220 + k, 450 + 3 * k, 3, 2, 1, 30, 1, 20);
            g_m1 = 16'hF00F; g_m2 = 16'hFFFF; g_m3 = 16'h3FFC;
            g_op = 4'(k); g_mode = 2'(k % 4); g_hts = 4'(k);
            run_blit("R3", 0);
        end
        stall = 1'b0;

        // R10 zero width and zero height
        setup(100, 800, 0, 5, 1, 1, 1, 1);
        g_op = 4'd15; g_mode = 2'd0;
        program_regs();
        cfg_write(5'd11, {16'd0, 1'b1, 11'd0, g_op});
        check(busy === 1'b0, "R10", "busy on empty width", {31'd0, busy}, 32'd0);
        setup(100, 800, 4, 0, 1, 1, 1, 1);
        program_regs();
        cfg_write(5'd11, {16'd0, 1'b1, 11'd0, g_op});
        check(busy === 1'b0, "R10", "busy on empty height", {31'd0, busy}, 32'd0);
        repeat (4) @(negedge clk);
        check(mem[800] === ref_mem[800], "R10", "memory untouched", {16'd0, mem[800]}, {16'd0, ref_mem[800]});

        // R2 writes during a run are ignored
        setup(10, 850, 8, 8, 1, 9, 1, 9);
        g_m1 = 16'hFF00; g_m2 = 16'hFFFF; g_m3 = 16'h00FF; g_op = 4'd6; g_mode = 2'd0; g_hts = 4'd0;
        run_blit("R2", 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule